// File: doc/BRIEF.md
# Double-Rate Write Capture with Byte Masking

This block takes write data from a 16-bit double-rate pin interface made of two 8-bit byte lanes. Each lane has its own strobe and its own mask pin. Each lane captures its data byte and its mask bit on both strobe edges, using separate rising-edge and falling-edge registers. The two half-cycle transfers of every lane are combined into one 32-bit word for a single-clock core write port, together with a 4-bit byte enable. Bytes whose mask was high are cleared.

The controller drives the strobes centred in the data eye, so every byte is stable around both strobe edges. After both edges of a pair have arrived, the controller raises `beatValid` for one core clock edge. A control unit counts the packed words against the programmed burst length and raises a one-cycle done flag after the last word of each burst. A new burst may follow with no idle cycle.

Top module: `ddrwr_capture`

## Requirements
- R1: While `rstN` is low, and after it is released, `coreWrEn`, `burstDone`, `coreByteEn` and `coreData` are all zero until the first accepted beat.
- R2: Packing follows a fixed layout. The byte on `dq[7:0]` at the rising edge of `dqs[0]` lands in `coreData[7:0]`. The byte on `dq[15:8]` at the rising edge of `dqs[1]` lands in `coreData[15:8]`. The bytes taken at the falling edges land in `coreData[23:16]` (lane 0) and `coreData[31:24]` (lane 1).
- R3: A mask pin sampled high at a strobe edge drives low the byte enable of the byte taken at that edge, and that byte of `coreData` reads zero. Enable bits map as follows: bit 0 is lane 0 rise, bit 1 is lane 1 rise, bit 2 is lane 0 fall, bit 3 is lane 1 fall. A byte whose mask is low keeps its enable high and its data intact.
- R4: A mask affects only the word it was sampled with. The next word's enables depend only on its own mask samples.
- R5: `beatValid` high at a clock edge makes `coreWrEn` high for exactly the following cycle, carrying that pair. With `beatValid` low, `coreWrEn` is low in the following cycle.
- R6: `burstSel` selects the burst length in transfers: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16. A burst is therefore 1, 2, 4 or 8 packed words. `burstDone` is high for one cycle, starting one cycle after the cycle in which the last word of the burst is on `coreWrEn`.
- R7: `burstSel` is taken only with the first word of a burst. Changes during the rest of the burst do not alter that burst's length.
- R8: The first word of a new burst may be given on the clock edge right after the previous burst's last word, and both bursts are counted correctly.
- R9: `beatValid` may drop between words of a burst. The word count resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dq | input | 16 | Write data pins, two byte lanes |
| dm | input | 2 | Per-lane write mask pins |
| dqs | input | 2 | Per-lane write strobes |
| beatValid | input | 1 | A complete rise/fall pair is held and may be taken |
| burstSel | input | 2 | Burst length code, taken at the first word |
| coreWrEn | output | 1 | Core write strobe |
| coreData | output | 32 | Packed word with masked bytes cleared |
| coreByteEn | output | 4 | Per-byte write enable |
| burstDone | output | 1 | One-cycle pulse after the last word of a burst |

## Verification
A wrong lane or edge selection shows up as swapped or stale bytes in `coreData` in the cycle after the beat is accepted. A mask register that holds its value too long shows up as a stray enable bit on the following word. A word counter or latched length that is wrong moves the `burstDone` pulse off its expected cycle, one cycle after the burst's last word. That error is visible by the end of the affected burst and again in every later burst, because the count does not recover. Back-to-back bursts, bursts with gaps and length changes in mid-burst all stress this counter.

// File: rtl/ddrwr_pkg.sv
package ddrwr_pkg;
  // Per-cycle commands from the control unit to the datapath
  typedef struct packed {
    logic load;   // take the held rise/fall pair this edge
    logic last;   // this word closes the current burst
  } wrStrobe_t;
endpackage

// File: rtl/ddrwr_ctrl.sv
module ddrwr_ctrl
  import ddrwr_pkg::*;
#(
  parameter int MAX_BURST = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic beatValid,
  input  logic [$clog2($clog2(MAX_BURST/2)+1)-1:0] burstSel,
  output wrStrobe_t strobes
);
  localparam int CNT_W = $clog2(MAX_BURST/2);
  localparam logic [CNT_W:0] ONE_WORD = 1;

  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W:0]   heldWords;
  logic [CNT_W:0]   wordsNow;
  logic             isLast;

  always_comb begin
    // burst length in words is 2^sel; only sampled at the first word
    wordsNow = (wordCnt == '0) ? (ONE_WORD << burstSel) : heldWords;
    isLast   = beatValid && ({1'b0, wordCnt} == (wordsNow - ONE_WORD));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt   <= '0;
      heldWords <= ONE_WORD;
    end else if (beatValid) begin
      if (wordCnt == '0) heldWords <= wordsNow;
      wordCnt <= isLast ? '0 : wordCnt + 1'b1;
    end
  end

  assign strobes.load = beatValid;
  assign strobes.last = isLast;
endmodule

// File: rtl/ddrwr_datapath.sv
module ddrwr_datapath
  import ddrwr_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LANES*LANE_W-1:0]   dq,
  input  logic [LANES-1:0]          dm,
  input  logic [LANES-1:0]          dqs,
  input  wrStrobe_t                 strobes,
  output logic                      coreWrEn,
  output logic [2*LANES*LANE_W-1:0] coreData,
  output logic [2*LANES-1:0]        coreByteEn,
  output logic                      burstDone
);
  localparam int PIN_W  = LANES * LANE_W;
  localparam int WORD_W = 2 * PIN_W;
  localparam int BYTES  = 2 * LANES;

  logic [PIN_W-1:0]  risePins, fallPins;
  logic [LANES-1:0]  riseMsk, fallMsk;
  logic [WORD_W-1:0] packedWord, maskedWord;
  logic [BYTES-1:0]  byteKeep;
  logic              lastQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] rData, fData;
    logic              rMask, fMask;
    always_ff @(posedge dqs[g]) begin
      rData <= dq[g*LANE_W +: LANE_W];
      rMask <= dm[g];
    end
    always_ff @(negedge dqs[g]) begin
      fData <= dq[g*LANE_W +: LANE_W];
      fMask <= dm[g];
    end
    assign risePins[g*LANE_W +: LANE_W] = rData;
    assign fallPins[g*LANE_W +: LANE_W] = fData;
    assign riseMsk[g] = rMask;
    assign fallMsk[g] = fMask;
  end

  // first beat in the low half, second beat in the high half
  assign packedWord = {fallPins, risePins};
  assign byteKeep   = ~{fallMsk, riseMsk};

  for (genvar b = 0; b < BYTES; b++) begin : gByte
    assign maskedWord[b*LANE_W +: LANE_W] =
      byteKeep[b] ? packedWord[b*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreWrEn   <= 1'b0;
      coreData   <= '0;
      coreByteEn <= '0;
      lastQ      <= 1'b0;
      burstDone  <= 1'b0;
    end else begin
      coreWrEn <= strobes.load;
      if (strobes.load) begin
        coreData   <= maskedWord;
        coreByteEn <= byteKeep;
      end
      lastQ     <= strobes.last;
      burstDone <= lastQ;
    end
  end
endmodule

// File: rtl/ddrwr_capture.sv
module ddrwr_capture
  import ddrwr_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int MAX_BURST = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LANES*LANE_W-1:0]   dq,
  input  logic [LANES-1:0]          dm,
  input  logic [LANES-1:0]          dqs,
  input  logic                      beatValid,
  input  logic [$clog2($clog2(MAX_BURST/2)+1)-1:0] burstSel,
  output logic                      coreWrEn,
  output logic [2*LANES*LANE_W-1:0] coreData,
  output logic [2*LANES-1:0]        coreByteEn,
  output logic                      burstDone
);
  wrStrobe_t strobes;

  ddrwr_ctrl #(.MAX_BURST(MAX_BURST)) ctrl (
    .clk(clk), .rstN(rstN), .beatValid(beatValid),
    .burstSel(burstSel), .strobes(strobes)
  );

  ddrwr_datapath #(.LANES(LANES), .LANE_W(LANE_W)) dpath (
    .clk(clk), .rstN(rstN), .dq(dq), .dm(dm), .dqs(dqs),
    .strobes(strobes), .coreWrEn(coreWrEn), .coreData(coreData),
    .coreByteEn(coreByteEn), .burstDone(burstDone)
  );
endmodule

// File: rtl/ddrwr_capture_chk.sv
module ddrwr_capture_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      beatValid,
  input logic                      coreWrEn,
  input logic [2*LANES*LANE_W-1:0] coreData,
  input logic [2*LANES-1:0]        coreByteEn,
  input logic                      burstDone
);
  AST_WRITE_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |=> coreWrEn); // R5

  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |=> !coreWrEn); // R5

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> $past(coreWrEn)); // R6

  for (genvar b = 0; b < 2*LANES; b++) begin : gChkByte
    AST_MASKED_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !coreByteEn[b] |-> (coreData[b*LANE_W +: LANE_W] == '0)); // R3
  end
endmodule

bind ddrwr_capture ddrwr_capture_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk (
  .clk(clk), .rstN(rstN), .beatValid(beatValid), .coreWrEn(coreWrEn),
  .coreData(coreData), .coreByteEn(coreByteEn), .burstDone(burstDone)
);

// File: tb/ddrwr_capture_test.sv
module ddrwr_capture_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dq = '0;
  logic [1:0]  dm = '0;
  logic [1:0]  dqs = '0;
  logic        beatValid = 1'b0;
  logic [1:0]  burstSel = '0;
  logic        coreWrEn;
  logic [31:0] coreData;
  logic [3:0]  coreByteEn;
  logic        burstDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // scoreboard item: {last, byteEn, data}
  logic [36:0] expQ[$];
  int  bCnt = 0;
  int  bWords = 1;
  logic prevLast = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ddrwr_capture uut (
    .clk(clk), .rstN(rstN), .dq(dq), .dm(dm), .dqs(dqs),
    .beatValid(beatValid), .burstSel(burstSel), .coreWrEn(coreWrEn),
    .coreData(coreData), .coreByteEn(coreByteEn), .burstDone(burstDone)
  );

  // Driver: one rise/fall pair on both lanes, then offer it at the next edge
  task automatic driveWord(input logic [31:0] w, input logic [3:0] msk,
                           input logic [1:0] sel);
    logic [31:0] expD;
    logic        isLast;
    @(posedge clk);
    #1 dq = w[15:0];  dm = msk[1:0];
    #4 dqs = 2'b11;
    #5 dq = w[31:16]; dm = msk[3:2];
    #5 dqs = 2'b00;
    #1 beatValid = 1'b1; burstSel = sel;
    for (int b = 0; b < 4; b++)
      expD[b*8 +: 8] = msk[b] ? 8'h00 : w[b*8 +: 8];
    if (bCnt == 0) bWords = 1 << sel;      // R7: length taken at first word
    isLast = (bCnt == bWords - 1);
    bCnt = isLast ? 0 : bCnt + 1;
    expQ.push_back({isLast, ~msk, expD});
  endtask

  task automatic idleCycle(input logic [1:0] sel);
    @(posedge clk);
    #16 beatValid = 1'b0; burstSel = sel;
  endtask

  // Monitor: compare results against the scoreboard between edges
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (burstDone || prevLast) begin
        checks++;
        if (burstDone !== prevLast) begin
          errors++;
          $display("FAIL R6 R7 R8 done got %0b exp %0b at %0t", burstDone, prevLast, $time);
        end
      end
      prevLast = 1'b0;
      if (coreWrEn) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected write got 1 exp 0 at %0t", $time);
        end else begin
          logic [36:0] it;
          it = expQ.pop_front();
          checks++;
          if (coreData !== it[31:0]) begin
            errors++;
            $display("FAIL R2 R3 data got %h exp %h", coreData, it[31:0]);
          end
          checks++;
          if (coreByteEn !== it[35:32]) begin
            errors++;
            $display("FAIL R3 R4 byteEn got %b exp %b", coreByteEn, it[35:32]);
          end
          prevLast = it[36];
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    checks++;   // R1: reset state
    if ({coreWrEn, burstDone, coreByteEn, coreData} !== '0) begin
      errors++;
      $display("FAIL R1 reset got %b %b %b %h exp all zero",
               coreWrEn, burstDone, coreByteEn, coreData);
    end
    rstN = 1'b1;
    idleCycle(2'd0);
    idleCycle(2'd0);
    checks++;   // R1 after release
    if ({coreWrEn, burstDone, coreByteEn, coreData} !== '0) begin
      errors++;
      $display("FAIL R1 post-reset got %b %b %b %h exp all zero",
               coreWrEn, burstDone, coreByteEn, coreData);
    end

    // R2 R6: single-word burst, distinct bytes per lane and edge
    driveWord(32'h44332211, 4'b0000, 2'd0);
    idleCycle(2'd0); idleCycle(2'd0); idleCycle(2'd0);

    // R3 R4: masks on word 1 only, word 2 unmasked
    driveWord(32'hDDCCBBAA, 4'b1001, 2'd1);
    driveWord(32'h87654321, 4'b0000, 2'd1);
    driveWord(32'h0F0E0D0C, 4'b0110, 2'd1);
    driveWord(32'h1A2B3C4D, 4'b1111, 2'd1);
    idleCycle(2'd1); idleCycle(2'd1);

    // R9: eight-transfer burst with gaps between words
    driveWord(32'hA0A1A2A3, 4'b0000, 2'd2);
    idleCycle(2'd2);
    driveWord(32'hB0B1B2B3, 4'b0100, 2'd2);
    idleCycle(2'd2); idleCycle(2'd2);
    driveWord(32'hC0C1C2C3, 4'b0000, 2'd2);
    driveWord(32'hD0D1D2D3, 4'b1000, 2'd2);
    idleCycle(2'd0); idleCycle(2'd0); idleCycle(2'd0);

    // R7: sixteen-transfer burst, select changes after first word
    driveWord(32'h01010101, 4'b0000, 2'd3);
    for (int k = 1; k < 8; k++)
      driveWord(32'h5A000000 ^ (k * 32'h01030507), 4'(k), 2'(k % 3));
    idleCycle(2'd0); idleCycle(2'd0); idleCycle(2'd0);

    // R8: back-to-back bursts with no idle cycle
    for (int k = 0; k < 3; k++)
      driveWord(32'h11110000 + 32'(k), 4'b0000, 2'd0);
    driveWord(32'h22220000, 4'b0010, 2'd1);
    driveWord(32'h22220001, 4'b0000, 2'd1);
    driveWord(32'h33330000, 4'b0000, 2'd0);

    // R5: idle cycles must produce no writes
    for (int k = 0; k < 6; k++) idleCycle(2'd3);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R5 missing writes got %0d left exp 0", expQ.size());
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule